// File: doc/BRIEF.md
# Round-Robin Next-Slot Selector

The selector picks which of K slaves is served next in a round-robin schedule. It keeps the currently served slave as a one-hot word in a small register. From that word and a request mask of eligible slaves, it forms a one-hot word for the next eligible slave. The search starts at the index just above the current slave, moves toward higher indices, and wraps from the top index back to index 0. The current slave's own bit is examined last, so a slave that is the only requester keeps its slot.

The search is a linear ripple of a few gates per bit. It is unrolled over two laps of the ring, so no combinational loop forms. It uses no subtractor, no encoder and no rotator. When the advance strobe is high and an eligible slave exists, the register loads the selected word. Otherwise the register keeps its value. The slave count is the parameter K (at least 2). Bit K-1 is the most significant bit of every K-bit word.

Top module: `rrn_sched`

## Requirements
- R1: While reset is low and in the cycle after it is released, `cur_o` equals the word with only bit K-1 set, so the first search begins at bit 0.
- R2: `next_o` has exactly one bit set: the first bit set in `mask_i` met when scanning from index c+1 upward modulo K, where c is the index of the bit set in `cur_o`.
- R3: When the only bit set in `mask_i` is bit c of the current slave, `next_o` equals `cur_o`.
- R4: When `mask_i` is all zeros, `next_o` is all zeros.
- R5: `next_o` never has more than one bit set and never sets a bit that is clear in `mask_i`.
- R6: When `adv_i` is high at a rising clock edge and `next_o` is nonzero, `cur_o` equals that `next_o` value after the edge.
- R7: When `adv_i` is high at a rising clock edge and `mask_i` is zero, `cur_o` is unchanged after the edge.
- R8: When `adv_i` is low at a rising clock edge, `cur_o` is unchanged after the edge, whatever `mask_i` is.
- R9: With K = 8, `cur_o` = 01000000 and `mask_i` = 00001010, `next_o` is 00000010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Advance strobe: load the selected slave into the register |
| mask_i | input | K | Eligible slaves, one bit per slave |
| next_o | output | K | One-hot selected next slave, or zero when nothing is eligible |
| cur_o | output | K | One-hot currently scheduled slave |

## Verification
A wrong current-slave register shows at the ports at once. `next_o` follows the register combinationally, so within the same cycle it names a slave that differs from the upward-wrapping scan. A register that loads on the wrong condition shows in `cur_o` one edge after the strobe. The bench moves the current slave to every position. At each position it compares `next_o` with a scan model for random masks. This catches a break in the ripple chain, or a wrap done wrongly, the first time a mask needs that stage.

// File: rtl/rrn_pkg.sv
package rrn_pkg;
    localparam int unsigned RRN_DEFAULT_K = 8;
endpackage

// File: rtl/rrn_onehot_fix.sv
// Passes a one-hot word through; any other word becomes bit K-1.
module rrn_onehot_fix #(
    parameter int unsigned K = rrn_pkg::RRN_DEFAULT_K
) (
    input  logic [K-1:0] raw_i,
    output logic [K-1:0] fixed_o
);
    localparam logic [K-1:0] TOP_BIT = {1'b1, {(K-1){1'b0}}};

    logic [K:0]   seen;
    logic [K-1:0] dup;

    assign seen[0] = 1'b0;
    for (genvar b = 0; b < K; b++) begin : g_scan
        assign dup[b]    = raw_i[b] & seen[b];
        assign seen[b+1] = seen[b] | raw_i[b];
    end

    assign fixed_o = (seen[K] && (dup == '0)) ? raw_i : TOP_BIT;
endmodule

// File: rtl/rrn_ring_chain.sv
// Ring search unrolled into two laps. A token starts at the current
// bit during lap one only. It rides upward until a masked bit takes it.
module rrn_ring_chain #(
    parameter int unsigned K = rrn_pkg::RRN_DEFAULT_K
) (
    input  logic [K-1:0] cur_i,
    input  logic [K-1:0] mask_i,
    output logic [K-1:0] pick_o
);
    localparam int unsigned STAGES = 2 * K;

    logic [STAGES-1:0] tok;
    logic [STAGES-1:0] hit;

    assign tok[0] = 1'b0;

    for (genvar j = 0; j < STAGES; j++) begin : g_stage
        localparam int unsigned B = j % K;
        assign hit[j] = tok[j] & mask_i[B];
        if (j < STAGES - 1) begin : g_link
            if (j < K) begin : g_lap1
                assign tok[j+1] = cur_i[B] | (tok[j] & ~mask_i[B]);
            end else begin : g_lap2
                assign tok[j+1] = tok[j] & ~mask_i[B];
            end
        end
    end

    for (genvar b = 0; b < K; b++) begin : g_fold
        assign pick_o[b] = hit[b] | hit[b+K];
    end
endmodule

// File: rtl/rrn_sched.sv
module rrn_sched #(
    parameter int unsigned K = rrn_pkg::RRN_DEFAULT_K
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    input  logic [K-1:0] mask_i,
    output logic [K-1:0] next_o,
    output logic [K-1:0] cur_o
);
    localparam logic [K-1:0] TOP_BIT = {1'b1, {(K-1){1'b0}}};

    logic [K-1:0] cur_q;
    logic [K-1:0] cur_safe;
    logic [K-1:0] pick;

    rrn_onehot_fix #(.K(K)) u_fix (
        .raw_i  (cur_q),
        .fixed_o(cur_safe)
    );

    rrn_ring_chain #(.K(K)) u_chain (
        .cur_i (cur_safe),
        .mask_i(mask_i),
        .pick_o(pick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= TOP_BIT;
        end else if (adv_i && (pick != '0)) begin
            cur_q <= pick;
        end
    end

    assign next_o = pick;
    assign cur_o  = cur_q;
endmodule

// File: rtl/rrn_sched_chk.sv
module rrn_sched_chk #(
    parameter int unsigned K = rrn_pkg::RRN_DEFAULT_K
) (
    input logic         clk,
    input logic         rst_n,
    input logic         adv_i,
    input logic [K-1:0] mask_i,
    input logic [K-1:0] next_o,
    input logic [K-1:0] cur_o
);
    AST_CUR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(cur_o)); // R1
    AST_PICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(next_o)); // R5
    AST_PICK_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (next_o & ~mask_i) == '0); // R5
    AST_PICK_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i != '0) |-> (next_o != '0)); // R2
    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |-> (next_o == '0)); // R4
    AST_SELF_RESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == cur_o) |-> (next_o == cur_o)); // R3
    AST_ADV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && next_o != '0) |=> (cur_o == $past(next_o))); // R6
    AST_ADV_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && mask_i == '0) |=> (cur_o == $past(cur_o))); // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> (cur_o == $past(cur_o))); // R8
endmodule

bind rrn_sched rrn_sched_chk #(.K(K)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (adv_i),
    .mask_i(mask_i),
    .next_o(next_o),
    .cur_o (cur_o)
);

// File: tb/rrn_sched_tb.sv
`timescale 1ns/1ps
module rrn_sched_tb;
    localparam int unsigned K = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         adv_i = 1'b0;
    logic [K-1:0] mask_i = '0;
    logic [K-1:0] next_o;
    logic [K-1:0] cur_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rrn_sched #(.K(K)) u_dut (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_i),
        .mask_i(mask_i), .next_o(next_o), .cur_o(cur_o)
    );

    function automatic logic [K-1:0] model_next(input logic [K-1:0] cur,
                                                input logic [K-1:0] mask);
        int c = K - 1;
        for (int i = 0; i < K; i++) if (cur[i]) c = i;
        for (int s = 1; s <= K; s++) begin
            int idx = (c + s) % K;
            if (mask[idx]) return K'(1) << idx;
        end
        return '0;
    endfunction

    task automatic check(input string req, input logic [K-1:0] act,
                         input logic [K-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Place the current slave at position p via a single-bit mask.
    task automatic move_to(input int p);
        @(negedge clk);
        mask_i = K'(1) << p;
        adv_i  = 1'b1;
        @(negedge clk);
        adv_i  = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [K-1:0] m;
        logic [K-1:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 reset", cur_o, 8'b1000_0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", cur_o, 8'b1000_0000);
        mask_i = 8'b1000_0001;
        #1 check("R1 search from bit0", next_o, 8'b0000_0001);

        // R2 / R5 random masks at every current position
        for (int p = 0; p < K; p++) begin
            move_to(p);
            check("R6 load", cur_o, K'(1) << p);
            for (int n = 0; n < 24; n++) begin
                @(negedge clk);
                m = K'($urandom());
                mask_i = m;
                #1 check("R2 scan", next_o, model_next(cur_o, m));
                checks++;
                if ((next_o & ~m) != '0) begin
                    fails++;
                    $display("FAIL R5 actual=%b expected subset of %b", next_o, m);
                end
            end
            @(negedge clk);
            mask_i = K'(1) << p;
            #1 check("R3 reselect", next_o, K'(1) << p);
            @(negedge clk);
            mask_i = '0;
            #1 check("R4 empty", next_o, '0);
        end

        // R7: advance with empty mask leaves register
        move_to(3);
        held = cur_o;
        @(negedge clk);
        mask_i = '0; adv_i = 1'b1;
        @(negedge clk);
        adv_i = 1'b0;
        check("R7 empty advance", cur_o, held);

        // R8: mask changes without advance do not move register
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            mask_i = K'($urandom()) | 8'b0000_0001;
        end
        @(negedge clk);
        check("R8 hold", cur_o, held);

        // R9 worked example, then wrap advance
        move_to(6);
        mask_i = 8'b0000_1010;
        #1 check("R9 example", next_o, 8'b0000_0010);
        @(negedge clk);
        adv_i = 1'b1;
        @(negedge clk);
        adv_i = 1'b0;
        check("R6 wrap load", cur_o, 8'b0000_0010);
        #1 check("R2 after wrap", next_o, 8'b0000_1000);

        finish_run();
    end
endmodule